// File: doc/BRIEF.md
# Byte FIFO with Water-Level Alerts

This block is a 64-entry, byte-wide synchronous FIFO. A single programmable water level drives two warning flags. The high alert rises when the free space left in the buffer falls to the water level or below. The low alert rises when the number of stored bytes falls to the water level or below. A producer that sees the high alert can slow down before it is stalled. A consumer that sees the low alert knows the buffer is nearly drained.

Both data sides use valid/ready. A byte is written on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low exactly while the FIFO is full. A byte is read on an edge where `out_valid` and `out_ready` are both high. `out_valid` is high exactly while the FIFO holds data, and the oldest byte is presented on `out_data` without waiting for a request.

A producer that keeps `in_valid` high against a low `in_ready` loses that byte, and the block records the loss in a sticky overflow flag. A consumer that asserts `out_ready` while nothing is valid changes nothing. The water level is held in an 8-bit register loaded through a write strobe. A synchronous flush empties the buffer.

Top module: `wl_fifo`

## Requirements
- R1: After reset, fill_count is 0, empty is 1, full is 0, in_ready is 1, out_valid is 0, overflow is 0, the water level is 8, lo_alert is 1 and hi_alert is 0.
- R2: A write occurs on an edge where in_valid and in_ready are both 1, and in_ready equals NOT full. Each write raises fill_count by 1 from the next cycle. full is 1 exactly when fill_count is 64.
- R3: out_valid equals NOT empty, and out_data shows the oldest stored byte while out_valid is 1. A read on an edge with out_valid and out_ready both 1 removes that byte, so bytes leave in the order they were written.
- R4: A write and a read on the same edge while the FIFO is neither empty nor full leave fill_count unchanged and keep the order of the bytes. A write and a read on the same edge while the FIFO is empty store the byte and ignore the read.
- R5: A write attempt while full, meaning in_valid is 1 and in_ready is 0, is dropped and leaves fill_count and the stored bytes unchanged. From the next cycle overflow is 1, and it stays 1 until reset. A flush does not clear it.
- R6: A read attempt while empty leaves fill_count unchanged. out_data then keeps showing the last byte that was read.
- R7: An edge with level_we at 1 loads level_wdata[5:0] as the water level. Bits 7 to 6 are discarded. The new level governs both alerts from the next cycle.
- R8: hi_alert is 1 exactly when (64 - fill_count) <= water level.
- R9: lo_alert is 1 exactly when fill_count <= water level.
- R10: An edge with flush at 1 empties the FIFO, so fill_count becomes 0 and lo_alert becomes 1. A write or read on the same edge is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous empty request |
| in_valid | input | 1 | Write side: byte offered |
| in_ready | output | 1 | Write side: space available |
| in_data | input | 8 | Write side: byte |
| out_valid | output | 1 | Read side: byte available |
| out_ready | input | 1 | Read side: byte taken |
| out_data | output | 8 | Read side: oldest byte, or the last byte read while empty |
| level_we | input | 1 | Water-level register write strobe |
| level_wdata | input | 8 | Water-level register write value, bits 5:0 used |
| fill_count | output | 7 | Bytes stored, 0 to 64 |
| full | output | 1 | 64 bytes stored |
| empty | output | 1 | No bytes stored |
| overflow | output | 1 | Sticky: a write was dropped while full |
| hi_alert | output | 1 | Free space at or below the water level |
| lo_alert | output | 1 | Stored bytes at or below the water level |

## Verification
Every effect of a write, read, flush or level load appears in the cycle after the edge that takes it. This covers fill_count, full, empty, the ready and valid flags, overflow and both alerts, because each of them is a function of registered count or level state only. out_data is the exception to "next cycle only" in one sense: it depends only on registered state, so it is valid at any time and is checked before each read as well as after. The bench drives inputs on the falling edge and samples on the next falling edge, which puts exactly one rising edge between a stimulus and its check. Each water level in the sweep is checked at every fill count from 0 to 64, both while filling and while draining.

// File: rtl/wl_fifo_pkg.sv
package wl_fifo_pkg;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned LEVEL_W   = 6;
  localparam logic [7:0]  LEVEL_RST = 8'h08;

  typedef struct packed {
    logic flush;
    logic push;
    logic pop;
  } fifo_req_t;
endpackage

// File: rtl/wl_fifo_level.sv
module wl_fifo_level #(
  parameter int unsigned CW = 8,
  parameter int unsigned LW = 6,
  parameter logic [CW-1:0] RST = 8'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [LW-1:0] level
);
  // upper field bits are reserved and never stored
  logic unused_rsvd;
  assign unused_rsvd = ^wdata[CW-1:LW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  level <= RST[LW-1:0];
    else if (we) level <= wdata[LW-1:0];
  end
endmodule

// File: rtl/wl_fifo_ctrl.sv
module wl_fifo_ctrl
  import wl_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fifo_req_t     req,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          rd_take,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          overflow
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok, drop;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign push_ok = req.push && !full  && !req.flush;
  assign pop_ok  = req.pop  && !empty && !req.flush;
  assign drop    = req.push &&  full  && !req.flush;

  assign wr_en   = push_ok;
  assign rd_take = pop_ok;
  assign wr_addr = wr_ptr;
  assign rd_addr = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (req.flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    overflow <= 1'b0;
    else if (drop) overflow <= 1'b1;
  end
endmodule

// File: rtl/wl_fifo_store.sv
module wl_fifo_store #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_take,
  input  logic             empty,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // keeps the byte most recently handed out, shown while empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= '0;
    else if (rd_take) last_q <= mem[rd_addr];
  end

  assign rd_data = empty ? last_q : mem[rd_addr];
endmodule

// File: rtl/wl_fifo_alert.sv
module wl_fifo_alert #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LW = 6,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned MW = (CW > LW) ? CW : LW
) (
  input  logic [CW-1:0] count,
  input  logic [LW-1:0] level,
  output logic          hi_alert,
  output logic          lo_alert
);
  logic [MW-1:0] used_x, free_x, lvl_x;

  always_comb begin
    used_x   = MW'(count);
    free_x   = MW'(DEPTH) - used_x;
    lvl_x    = MW'(level);
    hi_alert = (free_x <= lvl_x);
    lo_alert = (used_x <= lvl_x);
  end
endmodule

// File: rtl/wl_fifo.sv
module wl_fifo
  import wl_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  input  logic             level_we,
  input  logic [CFG_W-1:0] level_wdata,
  output logic [CW-1:0]    fill_count,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             hi_alert,
  output logic             lo_alert
);
  fifo_req_t           req;
  logic                wr_en, rd_take;
  logic [AW-1:0]       wr_addr, rd_addr;
  logic [LEVEL_W-1:0]  level;

  assign req = '{flush: flush, push: in_valid, pop: out_ready};

  wl_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_take(rd_take),
    .count(fill_count), .full(full), .empty(empty), .overflow(overflow)
  );

  wl_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_addr(rd_addr), .rd_take(rd_take), .empty(empty), .rd_data(out_data)
  );

  wl_fifo_level #(.CW(CFG_W), .LW(LEVEL_W), .RST(LEVEL_RST)) u_level (
    .clk(clk), .rst_n(rst_n), .we(level_we), .wdata(level_wdata), .level(level)
  );

  wl_fifo_alert #(.DEPTH(DEPTH), .LW(LEVEL_W)) u_alert (
    .count(fill_count), .level(level), .hi_alert(hi_alert), .lo_alert(lo_alert)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;
endmodule

// File: rtl/wl_fifo_chk.sv
module wl_fifo_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic [CW-1:0]    fill_count,
  input logic             full,
  input logic             empty,
  input logic             overflow,
  input logic             hi_alert,
  input logic             lo_alert
);
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (!in_ready && hi_alert && !empty));

  a_r3_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!out_valid && lo_alert));

  a_r4_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready && !flush) |=> $stable(fill_count));

  a_r5_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !flush) |=> overflow);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r6_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid && !in_valid && !flush) |=> ($stable(fill_count) && $stable(out_data)));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && fill_count == '0 && lo_alert));
endmodule

bind wl_fifo wl_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .fill_count(fill_count), .full(full), .empty(empty), .overflow(overflow),
  .hi_alert(hi_alert), .lo_alert(lo_alert)
);

// File: tb/wl_fifo_tb.sv
`timescale 1ns/1ps
module wl_fifo_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, in_valid = 1'b0, out_ready = 1'b0, level_we = 1'b0;
  logic [7:0] in_data = '0, level_wdata = '0;
  logic       in_ready, out_valid, full, empty, overflow, hi_alert, lo_alert;
  logic [7:0] out_data;
  logic [6:0] fill_count;

  int n_chk = 0, n_bad = 0;
  int lvl = 8;

  always #2.5 clk = ~clk;

  wl_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .level_we(level_we), .level_wdata(level_wdata), .fill_count(fill_count),
    .full(full), .empty(empty), .overflow(overflow), .hi_alert(hi_alert), .lo_alert(lo_alert)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // drive for one rising edge, return at the following falling edge
  task automatic drive(input logic p, input logic [7:0] d, input logic q,
                       input logic f, input logic we, input logic [7:0] wd);
    in_valid = p; in_data = d; out_ready = q; flush = f;
    level_we = we; level_wdata = wd;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0; flush = 1'b0; level_we = 1'b0;
  endtask

  function automatic int pat(input int s, input int i);
    return (s * 37 + i * 5 + 1) & 255;
  endfunction

  function automatic int alt(input int k);
    return (k * 11 + 7) & 255;
  endfunction

  task automatic chk_alerts(input string tag, input int c);
    chk({tag, " R8 hi_alert"}, int'(hi_alert), int'((64 - c) <= lvl));
    chk({tag, " R9 lo_alert"}, int'(lo_alert), int'(c <= lvl));
  endtask

  int raw_lv [6] = '{8, 0, 63, 195, 31, 96};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(fill_count), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 lo_alert", int'(lo_alert), 1);
    chk("R1 hi_alert", int'(hi_alert), 0);

    // sweep every fill level under several water levels
    for (int s = 0; s < 6; s++) begin
      if (s > 0) begin
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R10 flush count", int'(fill_count), 0);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'(raw_lv[s]));
        lvl = raw_lv[s] & 63;   // R7 bits 7:6 discarded
        chk_alerts("R7 load", 0);
      end
      for (int i = 0; i < 64; i++) begin
        drive(1'b1, 8'(pat(s, i)), 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R2 count", int'(fill_count), i + 1);
        chk("R2 full", int'(full), int'(i == 63));
        chk("R2 in_ready", int'(in_ready), int'(i != 63));
        chk("R3 head", int'(out_data), pat(s, 0));
        chk_alerts("fill", i + 1);
      end
      if (s == 0) begin
        chk("R5 no overflow yet", int'(overflow), 0);
        drive(1'b1, 8'hEE, 1'b0, 1'b0, 1'b0, 8'h00);
        chk("R5 count held", int'(fill_count), 64);
        chk("R5 overflow set", int'(overflow), 1);
      end
      for (int j = 0; j < 64; j++) begin
        chk("R3 order", int'(out_data), pat(s, j));
        chk("R3 out_valid", int'(out_valid), 1);
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R3 count", int'(fill_count), 63 - j);
        chk("R3 empty", int'(empty), int'(j == 63));
        chk_alerts("drain", 63 - j);
      end
      if (s == 0) begin
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
        chk("R6 count", int'(fill_count), 0);
        chk("R6 last byte", int'(out_data), pat(0, 63));
      end
      if (s == 1) chk("R5 survives flush", int'(overflow), 1);
    end

    // paired write and read in the middle
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    for (int k = 0; k < 5; k++) drive(1'b1, 8'(alt(k)), 1'b0, 1'b0, 1'b0, 8'h00);
    for (int k = 0; k < 20; k++) begin
      drive(1'b1, 8'(alt(5 + k)), 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R4 count", int'(fill_count), 5);
      chk("R4 order", int'(out_data), alt(k + 1));
    end
    // paired while empty: byte kept, read ignored
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    drive(1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R4 empty pair count", int'(fill_count), 1);
    chk("R4 empty pair data", int'(out_data), 8'h5A);
    // paired while full: write dropped, read taken
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    for (int k = 0; k < 64; k++) drive(1'b1, 8'(alt(k)), 1'b0, 1'b0, 1'b0, 8'h00);
    drive(1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R5 full pair count", int'(fill_count), 63);
    for (int k = 1; k < 64; k++) begin
      chk("R5 contents kept", int'(out_data), alt(k));
      drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
    end
    chk("R5 drained", int'(empty), 1);

    // flush beats a same-edge write and read
    for (int k = 0; k < 3; k++) drive(1'b1, 8'(k), 1'b0, 1'b0, 1'b0, 8'h00);
    drive(1'b1, 8'h77, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R10 count", int'(fill_count), 0);
    chk("R10 empty", int'(empty), 1);
    chk_alerts("R10", 0);
    chk("R10 overflow kept", int'(overflow), 1);

    // level load takes effect on the next cycle
    for (int k = 0; k < 10; k++) drive(1'b1, 8'(k), 1'b0, 1'b0, 1'b0, 8'h00);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'd10); lvl = 10;
    chk("R7 level 10 lo", int'(lo_alert), 1);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'd9); lvl = 9;
    chk("R7 level 9 lo", int'(lo_alert), 0);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hCA); lvl = 10;
    chk("R7 masked lo", int'(lo_alert), 1);
    chk("R7 masked hi", int'(hi_alert), 0);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'd54); lvl = 54;
    chk("R7 level 54 hi", int'(hi_alert), 1);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'd53); lvl = 53;
    chk("R7 level 53 hi", int'(hi_alert), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule